// File: doc/BRIEF.md
# Toggle-Flag Mailbox Clock-Domain Crossing

This block carries one multi-bit word at a time from a sending clock domain to a receiving clock domain, where the two clocks are unrelated. The word itself is never passed through per-bit synchronizers, because separate bits could be accepted on different receiver cycles and arrive torn. Instead, the sender parks the word in a holding register clocked by its own clock. In the same cycle it inverts a single request flag.

Only that one flag crosses the boundary, through a chain of flip-flops. The receiver compares the synchronized flag against the last value it saw. Every change, rising or falling, marks a new word. On a change the receiver captures the parked word and raises a valid strobe for exactly one receive clock. The receiver's record of the last seen flag also acts as an acknowledge flag, and that flag is synchronized back into the sending domain. The sender stays busy, and keeps the parked word frozen, until the acknowledge catches up with its request flag.

The block has room for one word only. A producer waits for busy to fall before it offers the next word.

Top module: `mbx_toggle_cdc`

## Requirements
- R1: While either reset is high, and on the first cycles after release, `snd_busy` and `rcv_valid` are 0 and `rcv_data` is all zeros. No transfer is reported unless a word has been written.
- R2: A write offered with `snd_wr`=1 while `snd_busy`=0 is accepted at that sending clock edge. `snd_busy` reads 1 from the next sending cycle on.
- R3: A write offered while `snd_busy`=1 is discarded. Its data is never delivered, and the word already parked is not disturbed.
- R4: Each accepted word produces exactly one `rcv_valid` pulse, and that pulse lasts exactly one receive clock cycle.
- R5: Words arrive in the order they were accepted, and each carries the exact bit pattern that was on `snd_data` when it was accepted.
- R6: `rcv_data` changes only in a cycle where `rcv_valid` is 1. Between pulses it holds the last delivered word.
- R7: After an accepted write, `snd_busy` returns to 0 once the acknowledge has come back. With two synchronizer stages this takes at most 40 sending cycles for receive clocks down to half the sending rate. A new write is then accepted.
- R8: In the cycle `rcv_valid` is 1, `rcv_data` already holds the new word. Data and strobe come from registers updated on the same edge.
- R9: R4 to R8 hold whether the receive clock is faster than, close to, or slower than the sending clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sending-domain clock |
| snd_rst | input | 1 | Sending-domain synchronous reset, active high |
| snd_data | input | DATA_W | Word to transfer |
| snd_wr | input | 1 | Write strobe; taken only when not busy |
| snd_busy | output | 1 | Mailbox occupied; writes are discarded |
| rcv_clk | input | 1 | Receiving-domain clock |
| rcv_rst | input | 1 | Receiving-domain synchronous reset, active high |
| rcv_data | output | DATA_W | Last delivered word, registered |
| rcv_valid | output | 1 | One-cycle strobe marking a new word on rcv_data |

## Verification
The bench sweeps 256 arithmetically generated words at each of three receive clock rates: faster than the sender, nearly equal to it, and slower than it. Every delivered word is compared against the accepted sequence. A design that reacted to only one edge of the flag would lose every second word. A strobe lasting several cycles would show up as duplicate deliveries. Every fifth transfer is followed by a write attempt while busy, carrying the inverted pattern. A sender that accepted it would overwrite the parked word or add an extra delivery. The bench also watches that `rcv_data` never moves without a strobe, and that busy clears within a bound after each word. A broken acknowledge path would leave busy stuck or release it before capture.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Minimum depth of a synchronizer chain crossing between the domains.
  localparam int unsigned MBX_MIN_SYNC = 2;

  // Sender-side occupancy of the single-word mailbox.
  typedef enum logic {
    SND_IDLE = 1'b0,
    SND_WAIT = 1'b1
  } snd_state_e;

endpackage

// File: rtl/mbx_sync_bit.sv
module mbx_sync_bit #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  localparam int unsigned N = (STAGES < mbx_pkg::MBX_MIN_SYNC) ? mbx_pkg::MBX_MIN_SYNC : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[N-2:0], d};
  end

  assign q = chain_q[N-1];

endmodule

// File: rtl/mbx_send_side.sv
module mbx_send_side #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              ack_async,
  output logic              busy,
  output logic [DATA_W-1:0] hold_word,
  output logic              req_tog
);

  import mbx_pkg::*;

  snd_state_e        state_q;
  logic [DATA_W-1:0] hold_q;
  logic              req_q;
  logic              ack_s;

  mbx_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_async),
    .q   (ack_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SND_IDLE;
      hold_q  <= '0;
      req_q   <= 1'b0;
    end else begin
      case (state_q)
        SND_IDLE: begin
          if (wr_en) begin
            hold_q  <= wr_data;
            req_q   <= ~req_q;
            state_q <= SND_WAIT;
          end
        end
        SND_WAIT: begin
          if (ack_s == req_q) state_q <= SND_IDLE;
        end
        default: state_q <= SND_IDLE;
      endcase
    end
  end

  assign busy      = (state_q == SND_WAIT);
  assign hold_word = hold_q;
  assign req_tog   = req_q;

endmodule

// File: rtl/mbx_recv_side.sv
module mbx_recv_side #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_async,
  input  logic [DATA_W-1:0] hold_word,
  output logic [DATA_W-1:0] data_out,
  output logic              valid,
  output logic              ack_tog
);

  logic              req_s;
  logic              seen_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              change;

  mbx_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_async),
    .q   (req_s)
  );

  assign change = (req_s != seen_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= change;
      if (change) begin
        seen_q <= req_s;
        data_q <= hold_word;
      end
    end
  end

  assign data_out = data_q;
  assign valid    = valid_q;
  assign ack_tog  = seen_q;

endmodule

// File: rtl/mbx_toggle_cdc.sv
module mbx_toggle_cdc #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              snd_clk,
  input  logic              snd_rst,
  input  logic [DATA_W-1:0] snd_data,
  input  logic              snd_wr,
  output logic              snd_busy,
  input  logic              rcv_clk,
  input  logic              rcv_rst,
  output logic [DATA_W-1:0] rcv_data,
  output logic              rcv_valid
);

  logic [DATA_W-1:0] hold_word;
  logic              req_tog;
  logic              ack_tog;

  mbx_send_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_send (
    .clk       (snd_clk),
    .rst       (snd_rst),
    .wr_data   (snd_data),
    .wr_en     (snd_wr),
    .ack_async (ack_tog),
    .busy      (snd_busy),
    .hold_word (hold_word),
    .req_tog   (req_tog)
  );

  mbx_recv_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_recv (
    .clk       (rcv_clk),
    .rst       (rcv_rst),
    .req_async (req_tog),
    .hold_word (hold_word),
    .data_out  (rcv_data),
    .valid     (rcv_valid),
    .ack_tog   (ack_tog)
  );

endmodule

// File: rtl/mbx_toggle_cdc_chk.sv
module mbx_toggle_cdc_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              snd_clk,
  input logic              snd_rst,
  input logic              snd_wr,
  input logic              snd_busy,
  input logic [DATA_W-1:0] hold_word,
  input logic              req_tog,
  input logic              rcv_clk,
  input logic              rcv_rst,
  input logic              rcv_valid,
  input logic [DATA_W-1:0] rcv_data
);

  AST_RESET_IDLE: assert property (@(posedge snd_clk) snd_rst |=> !snd_busy); // R1

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge snd_clk) disable iff (snd_rst)
    (snd_wr && !snd_busy) |=> snd_busy); // R2

  AST_BUSY_WRITE_NO_TOGGLE: assert property (@(posedge snd_clk) disable iff (snd_rst)
    snd_busy |=> $stable(req_tog)); // R3

  AST_HOLD_FROZEN: assert property (@(posedge snd_clk) disable iff (snd_rst)
    snd_busy |=> $stable(hold_word)); // R5

  AST_VALID_SINGLE: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
    rcv_valid |=> !rcv_valid); // R4

  AST_DATA_MOVES_WITH_VALID: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
    !$stable(rcv_data) |-> rcv_valid); // R6

  AST_DATA_MATCHES_HOLD: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
    rcv_valid |-> (rcv_data == hold_word)); // R8

endmodule

bind mbx_toggle_cdc mbx_toggle_cdc_chk #(.DATA_W(DATA_W)) u_chk (
  .snd_clk   (snd_clk),
  .snd_rst   (snd_rst),
  .snd_wr    (snd_wr),
  .snd_busy  (snd_busy),
  .hold_word (hold_word),
  .req_tog   (req_tog),
  .rcv_clk   (rcv_clk),
  .rcv_rst   (rcv_rst),
  .rcv_valid (rcv_valid),
  .rcv_data  (rcv_data)
);

// File: tb/mbx_toggle_cdc_bench.sv
`timescale 1ns/1ps
module mbx_toggle_cdc_bench;

  localparam int W = 8;

  logic         snd_clk = 1'b0;
  logic         rcv_clk = 1'b0;
  logic         snd_rst = 1'b1;
  logic         rcv_rst = 1'b1;
  logic         snd_wr  = 1'b0;
  logic [W-1:0] snd_data = '0;
  logic         snd_busy;
  logic         rcv_valid;
  logic [W-1:0] rcv_data;

  real rcv_half = 3.1;

  int checks   = 0;
  int failures = 0;
  int wr_idx   = 0;
  int rd_idx   = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q    [0:1023];
  bit           exp_poke [0:1023];
  logic [W-1:0] last_out = '0;

  mbx_toggle_cdc #(.DATA_W(W), .SYNC_STAGES(2)) u_mbx_toggle_cdc (
    .snd_clk   (snd_clk),
    .snd_rst   (snd_rst),
    .snd_data  (snd_data),
    .snd_wr    (snd_wr),
    .snd_busy  (snd_busy),
    .rcv_clk   (rcv_clk),
    .rcv_rst   (rcv_rst),
    .rcv_data  (rcv_data),
    .rcv_valid (rcv_valid)
  );

  always #2.5 snd_clk = ~snd_clk;
  initial forever #(rcv_half) rcv_clk = ~rcv_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Receive monitor: sampled on the falling edge, so each one-cycle strobe is seen once.
  always @(negedge rcv_clk) begin
    if (!rcv_rst) begin
      if (rcv_valid) begin
        if (rd_idx < wr_idx)
          chk(rcv_data == exp_q[rd_idx], exp_poke[rd_idx] ? "R3 word after ignored write" : "R5/R8 order and value",
              int'(rcv_data), int'(exp_q[rd_idx]));
        else
          chk(1'b0, "R4 extra delivery", rd_idx + 1, wr_idx);
        rd_idx++;
        last_out = rcv_data;
      end else if (rcv_data != last_out) begin
        chk(1'b0, "R6 data moved without strobe", int'(rcv_data), int'(last_out));
      end
    end
  end

  task automatic send(input logic [W-1:0] v, input bit poke);
    int n;
    n = 0;
    while (snd_busy && n < 40) begin
      @(negedge snd_clk);
      n++;
    end
    snd_data = v;
    snd_wr   = 1'b1;
    exp_q[wr_idx]    = v;
    exp_poke[wr_idx] = poke;
    wr_idx++;
    @(negedge snd_clk);
    snd_wr = 1'b0;
    chk(snd_busy == 1'b1, "R2 busy after accept", int'(snd_busy), 1);
    if (poke) begin
      snd_data = ~v;
      snd_wr   = 1'b1;
      @(negedge snd_clk);
      snd_wr   = 1'b0;
    end
    n = 0;
    while (snd_busy && n < 40) begin
      @(negedge snd_clk);
      n++;
    end
    chk(snd_busy == 1'b0, "R7 busy released", int'(snd_busy), 0);
  endtask

  initial begin
    real halves [3];
    halves[0] = 1.3;
    halves[1] = 2.6;
    halves[2] = 4.9;
    repeat (12) @(negedge snd_clk);
    chk(snd_busy == 1'b0,  "R1 busy in reset",  int'(snd_busy),  0);
    chk(rcv_valid == 1'b0, "R1 valid in reset", int'(rcv_valid), 0);
    chk(rcv_data == '0,    "R1 data in reset",  int'(rcv_data),  0);
    snd_rst = 1'b0;
    rcv_rst = 1'b0;
    repeat (10) @(negedge snd_clk);
    chk(rd_idx == 0,      "R1 no spurious transfer", rd_idx, 0);
    chk(snd_busy == 1'b0, "R1 idle after release",   int'(snd_busy), 0);
    for (int ph = 0; ph < 3; ph++) begin
      rcv_half = halves[ph];
      repeat (4) @(negedge snd_clk);
      for (int i = 0; i < 256; i++)
        send(W'((i * 37 + ph * 11 + 5) & 8'hFF), (i % 5) == 0);
      repeat (60) @(negedge snd_clk);
      chk(rd_idx == wr_idx, "R9 all words delivered at this clock ratio", rd_idx, wr_idx);
      chk(snd_busy == 1'b0, "R7 idle after drain", int'(snd_busy), 0);
    end
    chk(rd_idx == wr_idx, "R4 one delivery per accepted word", rd_idx, wr_idx);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", rd_idx, wr_idx);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule